// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Interface

This block is the digital command front end of a two-channel 14-bit voltage DAC. A host shifts a serial word into a 32-bit register over a clock line, a data line and a combined select/strobe line. The strobe is held low while bits are shifted. When the strobe is released (rising edge), the low 24 bits of the register are read as a command. Each command either loads a new output code, picks fast or slow settling, or powers down one channel or both.

The far end of the register comes out on a serial output. Several devices can therefore share the clock and strobe lines, with each serial output wired to the next device's serial input. One strobe release then makes every device in the chain act on its own word at the same time. The serial lines are sampled with the block's own system clock through two-stage synchronizers. All decoded results appear as registered per-channel outputs: the code, a fast-mode flag and a powered-down flag.

Top module: `dac_serial_front`

## Requirements
- R1: On each rising edge of the serial clock seen while the strobe is low, the shift register moves up by one bit and takes the data line into bit 0, so a word goes in most significant bit first. The serial output always shows bit 31, which is the bit shifted in 32 clocks earlier.
- R2: While the strobe is high, serial clock edges do not shift the register, and the serial output stays unchanged.
- R3: At a strobe rising edge the command is taken from the low 24 bits of the register: bits 23..20 are the control nibble, bits 19..16 are the address nibble and bits 15..0 are the data field. In a 32-bit frame the first 8 bits shifted in are don't-care.
- R4: Control nibble 0011 loads data bits 15..2 into the addressed channel's code, ignoring data bits 1..0, and clears that channel's powered-down flag.
- R5: Control nibble 0101 sets the addressed channel's fast flag, and 0110 clears it. The data field has no effect on either.
- R6: Control nibble 0100 sets the addressed channel's powered-down flag and leaves its code and speed unchanged.
- R7: Address nibble 0000 selects channel A, 0001 selects channel B and 1111 selects both. Any other address makes the command a no-operation.
- R8: Any control nibble other than 0011, 0100, 0101 and 0110 is a no-operation.
- R9: After reset both codes are zero, both channels are in slow mode and not powered down, and the shift register is all zeros, so the serial output is 0.
- R10: Channel outputs change only on a strobe rising edge, never while bits are being shifted.
- R11: When two devices are chained serial output to serial input and a 64-bit stream is sent under one strobe, the second device acts on the first 32 bits and the first device acts on the last 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_ld | input | 1 | Select (low) and load strobe (rising edge) |
| sdo | output | 1 | Serial data out, bit 31 of the shift register |
| ch_a_code | output | 14 | Channel A output code |
| ch_a_fast | output | 1 | Channel A fast-mode flag |
| ch_a_off | output | 1 | Channel A powered-down flag |
| ch_b_code | output | 14 | Channel B output code |
| ch_b_fast | output | 1 | Channel B fast-mode flag |
| ch_b_off | output | 1 | Channel B powered-down flag |

## Verification
Each serial line passes through two sampling flops before edge detection. A strobe rise therefore shows up on the channel outputs at the third system clock edge after it, and a serial clock rise moves the serial output at the third edge after it. The driver holds each serial clock level for four system clocks and waits eight system clocks after releasing the strobe. Only then does it post the expected state of both chained devices to the scoreboard. The monitor compares on a falling system clock edge, well after every result is due. Checks taken mid-frame and after serial clock edges with the strobe high confirm that nothing changes outside the strobe edge.

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int CODE_W = 14,
  parameter int SREG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              cs_ld,
  output logic              sdo,
  output logic [CODE_W-1:0] ch_a_code,
  output logic              ch_a_fast,
  output logic              ch_a_off,
  output logic [CODE_W-1:0] ch_b_code,
  output logic              ch_b_fast,
  output logic              ch_b_off
);
  localparam int DATA_W = CODE_W + 2;
  localparam int CMD_W  = DATA_W + 8;

  logic [2:0]        sck_s, cs_s;
  logic [1:0]        sdi_s;
  logic [SREG_W-1:0] shreg;
  logic [CODE_W-1:0] code_q [2];
  logic [1:0]        fast_q, off_q, sel;
  logic              sck_rise, cs_rise, shift_en;
  logic [3:0]        ctl, adr;
  logic [CODE_W-1:0] new_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      cs_s  <= {cs_s[1:0], cs_ld};
      sdi_s <= {sdi_s[0], sdi};
    end
  end

  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign cs_rise  = cs_s[1] & ~cs_s[2];
  assign shift_en = sck_rise & ~cs_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (shift_en) shreg <= {shreg[SREG_W-2:0], sdi_s[1]};
  end

  assign sdo = shreg[SREG_W-1];

  assign ctl      = shreg[CMD_W-1 -: 4];
  assign adr      = shreg[CMD_W-5 -: 4];
  assign new_code = shreg[DATA_W-1:2];
  assign sel[0]   = (adr == 4'h0) || (adr == 4'hF);
  assign sel[1]   = (adr == 4'h1) || (adr == 4'hF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) code_q[c] <= '0;
      fast_q <= '0;
      off_q  <= '0;
    end else if (cs_rise) begin
      for (int c = 0; c < 2; c++) begin
        if (sel[c]) begin
          case (ctl)
            4'b0011: begin code_q[c] <= new_code; off_q[c] <= 1'b0; end
            4'b0100: off_q[c]  <= 1'b1;
            4'b0101: fast_q[c] <= 1'b1;
            4'b0110: fast_q[c] <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  assign ch_a_code = code_q[0];
  assign ch_b_code = code_q[1];
  assign ch_a_fast = fast_q[0];
  assign ch_b_fast = fast_q[1];
  assign ch_a_off  = off_q[0];
  assign ch_b_off  = off_q[1];

  // R2
  sck_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s[1] |=> $stable(sdo));

  // R10
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> ($stable(ch_a_code) && $stable(ch_b_code) && $stable(fast_q) && $stable(off_q)));

  // R4
  load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && ctl == 4'b0011 && sel[0]) |=> (ch_a_code == $past(new_code) && !ch_a_off));

  // R5
  fast_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && ctl == 4'b0101 && sel[1]) |=> ch_b_fast);

  // R6
  off_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && ctl == 4'b0100 && sel[1]) |=> (ch_b_off && $stable(ch_b_code)));

  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && sel == 2'b00) |=> ($stable(fast_q) && $stable(off_q)));
endmodule

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sdi = 1'b0, cs_ld = 1'b1;
  logic sdo_a, sdo_b;
  logic [13:0] a_code [2], b_code [2];
  logic [1:0] a_fast, a_off, b_fast, b_off;

  always #2.5 clk = ~clk;

  dac_serial_front dut (.clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_ld(cs_ld), .sdo(sdo_a),
    .ch_a_code(a_code[0]), .ch_a_fast(a_fast[0]), .ch_a_off(a_off[0]),
    .ch_b_code(b_code[0]), .ch_b_fast(b_fast[0]), .ch_b_off(b_off[0]));
  dac_serial_front dut_b (.clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdo_a), .cs_ld(cs_ld), .sdo(sdo_b),
    .ch_a_code(a_code[1]), .ch_a_fast(a_fast[1]), .ch_a_off(a_off[1]),
    .ch_b_code(b_code[1]), .ch_b_fast(b_fast[1]), .ch_b_off(b_off[1]));

  typedef struct {
    string tag;
    logic [1:0][1:0][13:0] code;
    logic [1:0][1:0] fast, off;
    logic [1:0] sdo;
  } item_t;

  item_t q[$];
  logic chk_req = 1'b0;
  int checks = 0, fails = 0;

  logic [31:0] sh [2];
  logic [1:0][1:0][13:0] mcode;
  logic [1:0][1:0] mfast, moff;

  task automatic cmp(string tag, string what, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    item_t it;
    forever begin
      @(chk_req);
      it = q.pop_front();
      for (int d = 0; d < 2; d++) begin
        cmp(it.tag, $sformatf("dev%0d A code", d), a_code[d], it.code[d][0]);
        cmp(it.tag, $sformatf("dev%0d B code", d), b_code[d], it.code[d][1]);
        cmp(it.tag, $sformatf("dev%0d A fast", d), {13'd0, a_fast[d]}, {13'd0, it.fast[d][0]});
        cmp(it.tag, $sformatf("dev%0d B fast", d), {13'd0, b_fast[d]}, {13'd0, it.fast[d][1]});
        cmp(it.tag, $sformatf("dev%0d A off", d), {13'd0, a_off[d]}, {13'd0, it.off[d][0]});
        cmp(it.tag, $sformatf("dev%0d B off", d), {13'd0, b_off[d]}, {13'd0, it.off[d][1]});
      end
      cmp(it.tag, "R1 dev0 sdo", {13'd0, sdo_a}, {13'd0, it.sdo[0]});
      cmp(it.tag, "R1 dev1 sdo", {13'd0, sdo_b}, {13'd0, it.sdo[1]});
    end
  end

  task automatic check(string tag);
    item_t it;
    it.tag = tag; it.code = mcode; it.fast = mfast; it.off = moff;
    it.sdo = {sh[1][31], sh[0][31]};
    q.push_back(it);
    chk_req = ~chk_req;
    repeat (2) @(negedge clk);
  endtask

  task automatic apply(int d, logic [23:0] w);
    logic [3:0] ctl, adr;
    logic [1:0] sel;
    ctl = w[23:20]; adr = w[19:16];
    sel[0] = (adr == 4'h0) || (adr == 4'hF);
    sel[1] = (adr == 4'h1) || (adr == 4'hF);
    for (int c = 0; c < 2; c++) if (sel[c]) begin
      if (ctl == 4'b0011) begin mcode[d][c] = w[15:2]; moff[d][c] = 1'b0; end
      else if (ctl == 4'b0100) moff[d][c] = 1'b1;
      else if (ctl == 4'b0101) mfast[d][c] = 1'b1;
      else if (ctl == 4'b0110) mfast[d][c] = 1'b0;
    end
  endtask

  task automatic shift_bits(logic [31:0] w, int n, bit track);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      if (track) begin
        sh[1] = {sh[1][30:0], sh[0][31]};
        sh[0] = {sh[0][30:0], w[i]};
      end
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame_start();
    cs_ld = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (4) @(negedge clk);
    cs_ld = 1'b1;
    repeat (8) @(negedge clk);
    apply(0, sh[0][23:0]);
    apply(1, sh[1][23:0]);
  endtask

  task automatic send(logic [31:0] w, int n);
    frame_start();
    shift_bits(w, n, 1'b1);
    frame_end();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    sh[0] = '0; sh[1] = '0; mcode = '0; mfast = '0; moff = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reset state");

    send({8'h00, 4'b0011, 4'h0, 16'h48D3}, 24);
    check("R4 R3 load A 24-bit frame, low data bits ignored");
    send({8'hA5, 4'b0011, 4'h1, 16'hFFFC}, 32);
    check("R3 R4 load B 32-bit frame, top byte don't-care");
    send({8'h00, 4'b0101, 4'h0, 16'hDEAD}, 24);
    check("R5 fast A, data ignored");
    send({8'h00, 4'b0101, 4'hF, 16'h0000}, 24);
    check("R5 R7 fast both");
    send({8'h00, 4'b0110, 4'h1, 16'h1234}, 24);
    check("R5 slow B");
    send({8'h00, 4'b0100, 4'h1, 16'h5555}, 24);
    check("R6 power down B");
    send({8'h00, 4'b0011, 4'h1, 16'h0004}, 24);
    check("R4 load B clears power down");
    send({8'h00, 4'b0100, 4'hF, 16'h0000}, 24);
    check("R6 R7 power down both");
    send({8'h00, 4'b0011, 4'h2, 16'hAAAA}, 24);
    check("R7 address 0010 no-op");
    send({8'h00, 4'b0111, 4'h0, 16'h3333}, 24);
    check("R8 control 0111 no-op");
    send({8'h00, 4'b0000, 4'hF, 16'h7777}, 24);
    check("R8 control 0000 no-op");

    frame_start();
    shift_bits(32'h0030_FFFF, 20, 1'b1);
    check("R10 mid-frame outputs held");
    shift_bits(32'h0000_0FFF, 12, 1'b1);
    frame_end();
    check("R10 R1 frame completes after mid check");

    shift_bits(32'hFFFF_FFFF, 32, 1'b0);
    check("R2 serial clock ignored with strobe high");

    frame_start();
    shift_bits({8'h00, 4'b0011, 4'h0, 16'h2AF0}, 32, 1'b1);
    shift_bits({8'h3C, 4'b0011, 4'h1, 16'h1111}, 32, 1'b1);
    frame_end();
    check("R11 daisy chain, each device loads its own word");

    frame_start();
    shift_bits({8'h00, 4'b0110, 4'hF, 16'h0000}, 32, 1'b1);
    shift_bits({8'h00, 4'b0101, 4'h1, 16'h0000}, 32, 1'b1);
    frame_end();
    check("R11 R5 daisy chain speed commands");

    finish_run();
  end
endmodule